// File: doc/BRIEF.md
# Read-Shared Line Buffer for a Coherence Directory

This block is a small, fully associative store of whole cache lines that sits beside a coherence tag directory. When a line is clean and widely read, the directory places a copy here. Later reads of that line are then answered from the buffer itself. This avoids the usual sequence in which the directory forwards the request to a sharer tile and waits for that tile's acknowledgement before it handles the next request.

The directory sends three kinds of events: a read lookup, a write or ownership request, and a fill offer. A fill offer carries the line data, a clean flag and the population count of the line's sharer vector. By default, a fill is taken only when the line is clean and has at least `THRESH` readers. A mode input, `admitAll`, relaxes this so that any clean line with at least one reader is taken. A write that matches a buffered line removes that line, and the block reports that an entry was dropped. Storage is four 64-byte entries by default. Replacement uses true LRU, and a free entry is always chosen before any valid entry is evicted.

Top module: `rsb_top`

## Requirements
- R1: After reset, every entry is empty, `rspValid` and `invHit` are 0, and any read misses. This holds after a reset that is applied in the middle of operation as well.
- R2: Every read request produces `rspValid`=1 in the next cycle. A read of a buffered line gives `rspHit`=1 and that line's data in the same cycle.
- R3: With `admitAll`=0, a clean fill is stored only when `fillSharers` is at least `THRESH` (default 3). With 2 sharers, the fill is dropped and later reads of that address miss.
- R4: A fill with `fillClean`=0 is never stored, whatever its sharer count or mode.
- R5: With `admitAll`=1, a clean fill with `fillSharers` of 1 or more is stored. A fill with 0 sharers is dropped.
- R6: A write whose address matches a buffered line removes that line, and `invHit` pulses the next cycle. A write to an absent address leaves `invHit` at 0.
- R7: A qualifying fill to an address that is already buffered replaces that entry's data in place. It takes no second entry and evicts no other line.
- R8: A fill that needs an entry takes a free one when any exists, so no valid line is evicted.
- R9: When all entries are valid, a new line evicts the entry touched least recently. Both fills and read hits count as touches.
- R10: A read miss returns `rspHit`=0 and all-zero `rspData`.
- R11: A write and a fill to the same address in one cycle: the write wins and the fill is dropped. A read and a write to the same buffered address in one cycle: the read misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| admitAll | input | 1 | 1: admit any clean line with at least one reader |
| rdValid | input | 1 | Read lookup strobe |
| rdAddr | input | ADDR_W | Block address of the read |
| wrValid | input | 1 | Write or ownership request strobe |
| wrAddr | input | ADDR_W | Block address of the write |
| fillValid | input | 1 | Fill offer strobe |
| fillAddr | input | ADDR_W | Block address of the offered line |
| fillData | input | LINE_BYTES*8 | Offered line data |
| fillClean | input | 1 | Offered line is clean |
| fillSharers | input | SHARER_W | Population count of the line's sharer vector |
| rspValid | output | 1 | Read response valid, one cycle after the read |
| rspHit | output | 1 | Read response hit |
| rspData | output | LINE_BYTES*8 | Line data on a hit, zero on a miss |
| invHit | output | 1 | A write removed a buffered line last cycle |

## Verification
The assertions check the following on every cycle:
- no address is held by two valid entries;
- the recency ages always form a permutation;
- the fill-select and read-select vectors are at most one-hot;
- a read is always answered one cycle later, and a miss carries zero data;
- a dirty fill never increases the valid count;
- a write hit leaves its entry invalid.

The bench scenarios show the rest. These are the threshold levels in each mode, in-place update, the choice of a free slot before an LRU victim, the exact victim after a sequence of read hits, the two same-cycle conflict rules, and a reset in the middle of operation.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  // strobes from control to the datapath output stage
  typedef struct packed {
    logic rspLoad;   // a read was presented this cycle
    logic rspHit;    // that read hit a valid, non-killed entry
    logic invPulse;  // a write removed a valid entry
  } rsb_strobe_t;
endpackage

// File: rtl/rsb_datapath.sv
module rsb_datapath
  import rsb_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26,
  parameter int LINE_W  = 512
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  rdAddr,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [ADDR_W-1:0]  fillAddr,
  input  logic [LINE_W-1:0]  fillData,
  input  logic [ENTRIES-1:0] loadSel,
  input  logic [ENTRIES-1:0] readSel,
  input  rsb_strobe_t        strobe,
  output logic [ENTRIES-1:0] rdMatch,
  output logic [ENTRIES-1:0] wrMatch,
  output logic [ENTRIES-1:0] fillMatch,
  output logic               addrClash,
  output logic               rspValid,
  output logic               rspHit,
  output logic [LINE_W-1:0]  rspData,
  output logic               invHit
);
  logic [ADDR_W-1:0] tagQ  [ENTRIES];
  logic [LINE_W-1:0] dataQ [ENTRIES];
  logic [LINE_W-1:0] readMux;

  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           tagQ[g] <= '0;
      else if (loadSel[g]) tagQ[g] <= fillAddr;
    end
    always_ff @(posedge clk) begin
      if (loadSel[g]) dataQ[g] <= fillData;
    end
    assign rdMatch[g]   = (tagQ[g] == rdAddr);
    assign wrMatch[g]   = (tagQ[g] == wrAddr);
    assign fillMatch[g] = (tagQ[g] == fillAddr);
  end

  assign addrClash = (wrAddr == fillAddr);

  always_comb begin
    readMux = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (readSel[i]) readMux = readMux | dataQ[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspData  <= '0;
      invHit   <= 1'b0;
    end else begin
      rspValid <= strobe.rspLoad;
      rspHit   <= strobe.rspHit;
      rspData  <= strobe.rspHit ? readMux : '0;
      invHit   <= strobe.invPulse;
    end
  end

  // R8/R7: at most one entry written per cycle
  assert_load_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(loadSel));
  // R2: read data comes from a single entry
  assert_read_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(readSel));
  // R10: a miss never carries data
  assert_miss_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (rspData == '0));
endmodule

// File: rtl/rsb_ctrl.sv
module rsb_ctrl
  import rsb_pkg::*;
#(
  parameter int ENTRIES  = 4,
  parameter int SHARER_W = 7,
  parameter int THRESH   = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                admitAll,
  input  logic                rdValid,
  input  logic                wrValid,
  input  logic                fillValid,
  input  logic                fillClean,
  input  logic [SHARER_W-1:0] fillSharers,
  input  logic [ENTRIES-1:0]  rdMatch,
  input  logic [ENTRIES-1:0]  wrMatch,
  input  logic [ENTRIES-1:0]  fillMatch,
  input  logic                addrClash,
  output logic [ENTRIES-1:0]  loadSel,
  output logic [ENTRIES-1:0]  readSel,
  output rsb_strobe_t         strobe
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);
  localparam logic [SHARER_W-1:0] MIN_SHARE = SHARER_W'(THRESH);

  logic [ENTRIES-1:0] validQ;
  logic [IDX_W-1:0]   ageQ [ENTRIES];
  logic [ENTRIES-1:0] wrKill, rdHitVec, fillHitVec, victimVec, touchVec;
  logic [ENTRIES-1:0] ageSeen;
  logic [IDX_W-1:0]   touchAge;
  logic               fillQual, fillGo;

  assign wrKill     = wrValid ? (wrMatch & validQ) : '0;
  assign rdHitVec   = rdValid ? (rdMatch & validQ & ~wrKill) : '0;
  assign fillHitVec = fillMatch & validQ;
  assign fillQual   = fillClean &&
                      (admitAll ? (fillSharers != '0) : (fillSharers >= MIN_SHARE));
  assign fillGo     = fillValid && fillQual && !(wrValid && addrClash);

  // victim: lowest free entry, else the oldest one
  always_comb begin
    victimVec = '0;
    if (!(&validQ)) begin
      for (int i = ENTRIES - 1; i >= 0; i--)
        if (!validQ[i]) begin
          victimVec    = '0;
          victimVec[i] = 1'b1;
        end
    end else begin
      for (int i = 0; i < ENTRIES; i++)
        if (ageQ[i] == OLDEST) victimVec[i] = 1'b1;
    end
  end

  assign loadSel  = fillGo ? ((|fillHitVec) ? fillHitVec : victimVec) : '0;
  assign touchVec = (|loadSel) ? loadSel : rdHitVec;
  assign readSel  = rdHitVec;

  always_comb begin
    strobe          = '0;
    strobe.rspLoad  = rdValid;
    strobe.rspHit   = |rdHitVec;
    strobe.invPulse = |wrKill;
  end

  always_comb begin
    touchAge = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (touchVec[i]) touchAge = touchAge | ageQ[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      for (int i = 0; i < ENTRIES; i++) ageQ[i] <= IDX_W'(i);
    end else begin
      validQ <= (validQ & ~wrKill) | loadSel;
      if (|touchVec) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (touchVec[i])              ageQ[i] <= '0;
          else if (ageQ[i] < touchAge)  ageQ[i] <= ageQ[i] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    ageSeen = '0;
    for (int i = 0; i < ENTRIES; i++) ageSeen[ageQ[i]] = 1'b1;
  end

  // R9: recency ages stay a permutation, so exactly one entry is oldest
  assert_age_perm_R9: assert property (@(posedge clk) disable iff (!rstN)
    &ageSeen);
  // R7: an address is never held by two valid entries
  assert_no_dup_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rdMatch & validQ));
  // R4: a dirty offer never grows the valid set
  assert_dirty_reject_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && !fillClean) |=> ($countones(validQ) <= $past($countones(validQ))));
  // R6: a write hit leaves its entry invalid when no fill competes
  assert_write_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && |(wrMatch & validQ) && !fillValid) |=>
      ((validQ & $past(wrMatch & validQ)) == '0));
endmodule

// File: rtl/rsb_top.sv
module rsb_top
  import rsb_pkg::*;
#(
  parameter int ENTRIES    = 4,
  parameter int ADDR_W     = 26,
  parameter int LINE_BYTES = 64,
  parameter int TILES      = 64,
  parameter int THRESH     = 3,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int SHARER_W  = $clog2(TILES + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                admitAll,
  input  logic                rdValid,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  logic                wrValid,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic                fillValid,
  input  logic [ADDR_W-1:0]   fillAddr,
  input  logic [LINE_W-1:0]   fillData,
  input  logic                fillClean,
  input  logic [SHARER_W-1:0] fillSharers,
  output logic                rspValid,
  output logic                rspHit,
  output logic [LINE_W-1:0]   rspData,
  output logic                invHit
);
  logic [ENTRIES-1:0] loadSel, readSel, rdMatch, wrMatch, fillMatch;
  logic               addrClash;
  rsb_strobe_t        strobe;

  rsb_ctrl #(.ENTRIES(ENTRIES), .SHARER_W(SHARER_W), .THRESH(THRESH)) u_ctrl (
    .clk(clk), .rstN(rstN), .admitAll(admitAll),
    .rdValid(rdValid), .wrValid(wrValid), .fillValid(fillValid),
    .fillClean(fillClean), .fillSharers(fillSharers),
    .rdMatch(rdMatch), .wrMatch(wrMatch), .fillMatch(fillMatch),
    .addrClash(addrClash), .loadSel(loadSel), .readSel(readSel), .strobe(strobe)
  );

  rsb_datapath #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_dp (
    .clk(clk), .rstN(rstN), .rdAddr(rdAddr), .wrAddr(wrAddr),
    .fillAddr(fillAddr), .fillData(fillData),
    .loadSel(loadSel), .readSel(readSel), .strobe(strobe),
    .rdMatch(rdMatch), .wrMatch(wrMatch), .fillMatch(fillMatch),
    .addrClash(addrClash), .rspValid(rspValid), .rspHit(rspHit),
    .rspData(rspData), .invHit(invHit)
  );

  // R2: every read is answered on the next cycle
  assert_read_answered_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> rspValid);
  // R2: no response without a read
  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(rdValid));
  // R6: invalidation report only follows a write
  assert_inv_after_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    invHit |-> $past(wrValid));
endmodule

// File: tb/rsb_top_tb.sv
module rsb_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 26;
  localparam int LINE_W = 512;
  localparam int SHW    = 7;

  localparam logic [1:0] OP_RD = 2'd0, OP_FILL = 2'd1, OP_WR = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] addr;
    logic [7:0]  seed;
    logic [6:0]  shr;
    logic        clean;
    logic        all;
    logic        exp;
    logic [7:0]  expSeed;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{OP_RD,   16'h0101, 8'h00, 7'd0, 1'b1, 1'b0, 1'b0, 8'h00, 4'd10}, // R10 empty miss
    '{OP_FILL, 16'h0101, 8'h11, 7'd3, 1'b1, 1'b0, 1'b0, 8'h00, 4'd2},
    '{OP_RD,   16'h0101, 8'h00, 7'd0, 1'b1, 1'b0, 1'b1, 8'h11, 4'd2},  // R2 hit
    '{OP_FILL, 16'h0102, 8'h22, 7'd2, 1'b1, 1'b0, 1'b0, 8'h00, 4'd3},
    '{OP_RD,   16'h0102, 8'h00, 7'd0, 1'b1, 1'b0, 1'b0, 8'h00, 4'd3},  // R3 below threshold
    '{OP_FILL, 16'h0103, 8'h33, 7'd5, 1'b0, 1'b0, 1'b0, 8'h00, 4'd4},
    '{OP_RD,   16'h0103, 8'h00, 7'd0, 1'b1, 1'b0, 1'b0, 8'h00, 4'd4},  // R4 dirty
    '{OP_FILL, 16'h0104, 8'h44, 7'd1, 1'b1, 1'b1, 1'b0, 8'h00, 4'd5},
    '{OP_RD,   16'h0104, 8'h00, 7'd0, 1'b1, 1'b0, 1'b1, 8'h44, 4'd5},  // R5 admit-all
    '{OP_FILL, 16'h0105, 8'h55, 7'd0, 1'b1, 1'b1, 1'b0, 8'h00, 4'd5},
    '{OP_RD,   16'h0105, 8'h00, 7'd0, 1'b1, 1'b0, 1'b0, 8'h00, 4'd5},  // R5 zero sharers
    '{OP_FILL, 16'h0101, 8'h12, 7'd4, 1'b1, 1'b0, 1'b0, 8'h00, 4'd7},
    '{OP_RD,   16'h0101, 8'h00, 7'd0, 1'b1, 1'b0, 1'b1, 8'h12, 4'd7},  // R7 in place
    '{OP_FILL, 16'h0106, 8'h66, 7'd3, 1'b1, 1'b0, 1'b0, 8'h00, 4'd8},
    '{OP_FILL, 16'h0107, 8'h77, 7'd7, 1'b1, 1'b0, 1'b0, 8'h00, 4'd8},
    '{OP_RD,   16'h0104, 8'h00, 7'd0, 1'b1, 1'b0, 1'b1, 8'h44, 4'd7},  // R7 neighbour kept
    '{OP_FILL, 16'h0108, 8'h88, 7'd3, 1'b1, 1'b0, 1'b0, 8'h00, 4'd9},
    '{OP_RD,   16'h0101, 8'h00, 7'd0, 1'b1, 1'b0, 1'b0, 8'h00, 4'd9},  // R9 LRU gone
    '{OP_RD,   16'h0104, 8'h00, 7'd0, 1'b1, 1'b0, 1'b1, 8'h44, 4'd9},
    '{OP_RD,   16'h0106, 8'h00, 7'd0, 1'b1, 1'b0, 1'b1, 8'h66, 4'd9},
    '{OP_RD,   16'h0107, 8'h00, 7'd0, 1'b1, 1'b0, 1'b1, 8'h77, 4'd9},
    '{OP_RD,   16'h0108, 8'h00, 7'd0, 1'b1, 1'b0, 1'b1, 8'h88, 4'd9},
    '{OP_WR,   16'h0106, 8'h00, 7'd0, 1'b1, 1'b0, 1'b1, 8'h00, 4'd6},  // R6 inv
    '{OP_RD,   16'h0106, 8'h00, 7'd0, 1'b1, 1'b0, 1'b0, 8'h00, 4'd6},
    '{OP_WR,   16'h0102, 8'h00, 7'd0, 1'b1, 1'b0, 1'b0, 8'h00, 4'd6},  // R6 absent
    '{OP_FILL, 16'h0109, 8'h99, 7'd3, 1'b1, 1'b0, 1'b0, 8'h00, 4'd8},
    '{OP_RD,   16'h0104, 8'h00, 7'd0, 1'b1, 1'b0, 1'b1, 8'h44, 4'd8},  // R8 free slot used
    '{OP_RD,   16'h0107, 8'h00, 7'd0, 1'b1, 1'b0, 1'b1, 8'h77, 4'd8},
    '{OP_RD,   16'h0108, 8'h00, 7'd0, 1'b1, 1'b0, 1'b1, 8'h88, 4'd8},
    '{OP_RD,   16'h0109, 8'h00, 7'd0, 1'b1, 1'b0, 1'b1, 8'h99, 4'd8}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic admitAll = 1'b0, rdValid = 1'b0, wrValid = 1'b0, fillValid = 1'b0, fillClean = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0, wrAddr = '0, fillAddr = '0;
  logic [LINE_W-1:0] fillData = '0;
  logic [SHW-1:0]    fillSharers = '0;
  logic              rspValid, rspHit, invHit;
  logic [LINE_W-1:0] rspData;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rsb_top u_dut (
    .clk(clk), .rstN(rstN), .admitAll(admitAll),
    .rdValid(rdValid), .rdAddr(rdAddr), .wrValid(wrValid), .wrAddr(wrAddr),
    .fillValid(fillValid), .fillAddr(fillAddr), .fillData(fillData),
    .fillClean(fillClean), .fillSharers(fillSharers),
    .rspValid(rspValid), .rspHit(rspHit), .rspData(rspData), .invHit(invHit)
  );

  function automatic logic [LINE_W-1:0] lineOf(input logic [7:0] s);
    return {(LINE_W / 32){s, ~s, s ^ 8'h5a, 8'hc3}};
  endfunction

  task automatic checkBit(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic checkLine(input string tag, input logic [LINE_W-1:0] act,
                           input logic [LINE_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act[31:0], exp[31:0]);
    end
  endtask

  // one cycle of stimulus, applied at a falling edge, results read at the next one
  task automatic step(input logic rd, input logic [15:0] ra,
                      input logic wr, input logic [15:0] wa,
                      input logic fl, input logic [15:0] fa, input logic [7:0] fs,
                      input logic [6:0] shr, input logic cl, input logic all);
    rdValid = rd; rdAddr = ADDR_W'(ra);
    wrValid = wr; wrAddr = ADDR_W'(wa);
    fillValid = fl; fillAddr = ADDR_W'(fa); fillData = lineOf(fs);
    fillSharers = shr; fillClean = cl; admitAll = all;
    @(posedge clk);
    @(negedge clk);
    rdValid = 1'b0; wrValid = 1'b0; fillValid = 1'b0; admitAll = 1'b0;
  endtask

  task automatic readExpect(input string tag, input logic [15:0] a,
                            input logic hit, input logic [7:0] s);
    step(1'b1, a, 1'b0, 16'h0, 1'b0, 16'h0, 8'h0, 7'd0, 1'b0, 1'b0);
    checkBit({tag, " rspValid"}, rspValid, 1'b1);
    checkBit({tag, " rspHit"}, rspHit, hit);
    checkLine({tag, " rspData"}, rspData, hit ? lineOf(s) : '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet during and just after reset
    checkBit("R1 rspValid in reset", rspValid, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    checkBit("R1 rspValid after reset", rspValid, 1'b0);
    checkBit("R1 invHit after reset", invHit, 1'b0);

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      string tag;
      t = VECS[v];
      tag = $sformatf("R%0d row%0d", t.req, v);
      case (t.op)
        OP_RD: readExpect(tag, t.addr, t.exp, t.expSeed);
        OP_FILL: begin
          step(1'b0, 16'h0, 1'b0, 16'h0, 1'b1, t.addr, t.seed, t.shr, t.clean, t.all);
          checkBit({tag, " rspValid idle"}, rspValid, 1'b0);
        end
        default: begin
          step(1'b0, 16'h0, 1'b1, t.addr, 1'b0, 16'h0, 8'h0, 7'd0, 1'b0, 1'b0);
          checkBit({tag, " invHit"}, invHit, t.exp);
        end
      endcase
    end

    // R11: write and qualifying fill to one address in one cycle, the fill is lost
    step(1'b0, 16'h0, 1'b1, 16'h010a, 1'b1, 16'h010a, 8'hab, 7'd5, 1'b1, 1'b0);
    checkBit("R11 clash invHit", invHit, 1'b0);
    readExpect("R11 clash fill dropped", 16'h010a, 1'b0, 8'h00);
    // install it, then read and write it together: the read misses
    step(1'b0, 16'h0, 1'b0, 16'h0, 1'b1, 16'h010a, 8'hab, 7'd5, 1'b1, 1'b0);
    readExpect("R11 installed", 16'h010a, 1'b1, 8'hab);
    step(1'b1, 16'h010a, 1'b1, 16'h010a, 1'b0, 16'h0, 8'h0, 7'd0, 1'b0, 1'b0);
    checkBit("R11 same-cycle read rspValid", rspValid, 1'b1);
    checkBit("R11 same-cycle read misses", rspHit, 1'b0);
    checkBit("R6 same-cycle invHit", invHit, 1'b1);
    readExpect("R11 gone afterwards", 16'h010a, 1'b0, 8'h00);

    // R1: reset in mid-run empties the buffer
    readExpect("R1 pre-reset hit", 16'h0107, 1'b1, 8'h77);
    rstN = 1'b0;
    @(negedge clk);
    checkBit("R1 mid reset rspValid", rspValid, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    readExpect("R1 emptied by reset", 16'h0107, 1'b0, 8'h00);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule